// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block is the controller side of an outbound command ring held in memory. Software places 32-bit commands in the ring and then moves a write pointer register forward. The engine compares that pointer with its own read pointer. For each new entry it issues a read on a synchronous memory port and passes the returned word to a serial-link transmitter over a valid/ready handshake. It also reports the codec address that the command carries.

A small register port lets software set the ring base, pick the ring depth with a coded size field, move the write pointer, and start or stop fetching. The read pointer is cleared through a two-step handshake. Software writes the clear bit as 1 and reads it back as 1, which confirms the pointer is zero and holds off fetching. Software then writes the bit back to 0.

The read pointer always names the last entry already consumed. Each fetch therefore goes to the slot after it, so slot 0 is never fetched right after a clear. Only one memory read is in flight at a time, and the pointer moves only when the transmitter accepts the command.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset, tx_valid and mem_rd_en are 0, the read-pointer register (selector 3) reads 0, the size register (selector 1) reads 2 and the control register (selector 4) reads 0.
- R2: Size code bits 1:0 (selector 1) select the depth: 0 gives 2 entries, 1 gives 16, and 2 or 3 give 256. Pointers wrap modulo the depth. A write-pointer write (selector 2, bits 7:0) keeps only the low log2(depth) bits.
- R3: While fetching is allowed, the engine delivers the entries after the read pointer, up to and including the write pointer, in ring order. Entry i is read at address base + 4*i, with the base at selector 0. Nothing is fetched once the read pointer equals the write pointer.
- R4: Fetching pre-increments the read pointer. After a pointer clear with the write pointer at 0, nothing is fetched, and the first entry fetched is slot 1.
- R5: Writing selector 3 with bit 15 set clears the read pointer to 0 in the next cycle, and the register then reads 0x8000. While bit 15 stays set, no fetch starts. Writing bit 15 as 0 makes it read back 0 and lets fetching resume.
- R6: Control bit 0 (selector 4) gates fetching. While it is 0, no new memory read starts. A command already fetched is still delivered, and the read pointer then stops at that entry.
- R7: At most one memory read is outstanding. While tx_valid is high and tx_ready is low, tx_valid and tx_cmd hold. The read pointer changes only on a completed handshake or a clear.
- R8: tx_codec equals bits 31:28 of the command being presented.
- R9: ring_full is 1 exactly when (write pointer + 1) modulo the depth equals the read pointer.
- R10: While pwr_down is 1, the write-pointer register reads 0x0000FFFF and no fetch starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Controller powered down; halts fetching |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector: 0 base, 1 size, 2 write ptr, 3 read ptr, 4 control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_sel (combinational) |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd_data | input | DATA_W | Read data, valid the cycle after mem_rd_en |
| tx_valid | output | 1 | Command offered to the link |
| tx_ready | input | 1 | Link accepts the command |
| tx_cmd | output | DATA_W | Command word |
| tx_codec | output | 4 | Codec address, command bits 31:28 |
| ring_full | output | 1 | Ring has no free slot |

## Verification
If the read pointer is wrong, the result shows on mem_addr in the next fetch cycle. It also appears on the read-pointer readback, and later as a command that is missing, repeated or out of order on tx_cmd. A wrong wrap mask shows as soon as the write pointer passes the top of a small ring, so depths 2 and 16 are swept through many wraps and depth 256 is crossed once. A lost handshake or hold state shows within a cycle as tx_cmd changing under back-pressure, or as a fetch starting while control, clear or power-down should block it.

// File: rtl/cre_pkg.sv
package cre_pkg;

    localparam int PTR_W   = 8;   // largest ring is 256 entries
    localparam int RST_BIT = 15;  // read-pointer clear bit

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [2:0] {
        SEL_BASE = 3'd0,
        SEL_SIZE = 3'd1,
        SEL_WP   = 3'd2,
        SEL_RP   = 3'd3,
        SEL_CTRL = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_WAIT = 2'd1,
        F_SEND = 2'd2
    } fetch_st_e;

    typedef struct packed {
        logic run;
        logic rst_hold;
        ptr_t mask;
        ptr_t wp;
    } ring_cfg_t;

    // depth - 1 for a size code
    function automatic ptr_t ring_mask(input logic [1:0] code);
        case (code)
            2'd0:    ring_mask = ptr_t'(1);
            2'd1:    ring_mask = ptr_t'(15);
            default: ring_mask = '1;
        endcase
    endfunction

endpackage

// File: rtl/cre_regs.sv
module cre_regs
    import cre_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  ptr_t              rd_ptr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] ring_base,
    output ring_cfg_t         cfg,
    output logic              rp_clr
);

    logic [1:0]        size_code;
    logic [ADDR_W-1:0] base_q;
    ptr_t              wp_q;
    logic              run_q;
    logic              hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            size_code <= 2'd2;
            wp_q      <= '0;
            run_q     <= 1'b0;
            hold_q    <= 1'b0;
        end else if (reg_we) begin
            case (reg_sel)
                SEL_BASE: base_q    <= {reg_wdata[ADDR_W-1:2], 2'b00};
                SEL_SIZE: size_code <= reg_wdata[1:0];
                SEL_WP:   wp_q      <= reg_wdata[PTR_W-1:0] & ring_mask(size_code);
                SEL_RP:   hold_q    <= reg_wdata[RST_BIT];
                SEL_CTRL: run_q     <= reg_wdata[0];
                default:  ;
            endcase
        end
    end

    assign rp_clr    = reg_we && (reg_sel == SEL_RP) && reg_wdata[RST_BIT];
    assign ring_base = base_q;

    always_comb begin
        cfg.run      = run_q;
        cfg.rst_hold = hold_q;
        cfg.mask     = ring_mask(size_code);
        cfg.wp       = wp_q;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_BASE: reg_rdata = DATA_W'(base_q);
            SEL_SIZE: reg_rdata = DATA_W'(size_code);
            SEL_WP:   reg_rdata = pwr_down ? DATA_W'(16'hFFFF) : DATA_W'(wp_q);
            SEL_RP: begin
                reg_rdata[PTR_W-1:0] = rd_ptr;
                reg_rdata[RST_BIT]   = hold_q;
            end
            SEL_CTRL: reg_rdata = DATA_W'(run_q);
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/cre_fetch.sv
module cre_fetch
    import cre_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CODEC_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_down,
    input  ring_cfg_t          cfg,
    input  logic [ADDR_W-1:0]  ring_base,
    input  logic               rp_clr,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [DATA_W-1:0]  tx_cmd,
    output logic [CODEC_W-1:0] tx_codec,
    output ptr_t               rd_ptr
);

    localparam int BYTE_SHIFT = 2;

    fetch_st_e         state;
    ptr_t              nxt_q;
    logic [DATA_W-1:0] cmd_q;
    logic              stale_q;   // pointer cleared while a command was in flight
    ptr_t              nxt;
    logic              go;
    logic              accept;

    assign nxt    = (rd_ptr + ptr_t'(1)) & cfg.mask;
    assign go     = (state == F_IDLE) && cfg.run && !cfg.rst_hold && !pwr_down
                    && !rp_clr && (rd_ptr != cfg.wp);
    assign accept = (state == F_SEND) && tx_ready;

    assign mem_rd_en = go;
    assign mem_addr  = ring_base + (ADDR_W'(nxt) << BYTE_SHIFT);
    assign tx_valid  = (state == F_SEND);
    assign tx_cmd    = cmd_q;
    assign tx_codec  = cmd_q[DATA_W-1 -: CODEC_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= F_IDLE;
            nxt_q <= '0;
            cmd_q <= '0;
        end else begin
            case (state)
                F_IDLE: if (go) begin
                    nxt_q <= nxt;
                    state <= F_WAIT;
                end
                F_WAIT: begin
                    cmd_q <= mem_rd_data;
                    state <= F_SEND;
                end
                F_SEND: if (tx_ready) state <= F_IDLE;
                default: state <= F_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr  <= '0;
            stale_q <= 1'b0;
        end else begin
            if (rp_clr) begin
                rd_ptr  <= '0;
                stale_q <= (state != F_IDLE) && !accept;
            end else begin
                if (accept && !stale_q && !cfg.rst_hold) rd_ptr <= nxt_q;
                if (accept) stale_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cmd_ring_engine.sv
module cmd_ring_engine
    import cre_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CODEC_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwr_down,
    input  logic               reg_we,
    input  logic [2:0]         reg_sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [DATA_W-1:0]  tx_cmd,
    output logic [CODEC_W-1:0] tx_codec,
    output logic               ring_full
);

    ring_cfg_t         cfg;
    logic [ADDR_W-1:0] ring_base;
    logic              rp_clr;
    ptr_t              rd_ptr;

    cre_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .pwr_down  (pwr_down),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .rd_ptr    (rd_ptr),
        .reg_rdata (reg_rdata),
        .ring_base (ring_base),
        .cfg       (cfg),
        .rp_clr    (rp_clr)
    );

    cre_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODEC_W(CODEC_W)) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .pwr_down    (pwr_down),
        .cfg         (cfg),
        .ring_base   (ring_base),
        .rp_clr      (rp_clr),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rd_data (mem_rd_data),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_cmd      (tx_cmd),
        .tx_codec    (tx_codec),
        .rd_ptr      (rd_ptr)
    );

    assign ring_full = (((cfg.wp + ptr_t'(1)) & cfg.mask) == rd_ptr);

endmodule

// File: rtl/cre_chk.sv
module cre_chk
    import cre_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              pwr_down,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              mem_rd_en,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [DATA_W-1:0] tx_cmd,
    input ring_cfg_t         cfg,
    input ptr_t              rd_ptr
);

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_cmd));

    // R7
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en && !tx_valid);

    // R7
    ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rd_ptr) |-> $past(tx_valid && tx_ready)
            || $past(reg_we && reg_sel == 3'd3 && reg_wdata[RST_BIT]));

    // R3
    no_empty_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> rd_ptr != cfg.wp);

    // R5
    ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we && reg_sel == 3'd3 && reg_wdata[RST_BIT] |=> rd_ptr == '0);

    // R5
    hold_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.rst_hold |-> !mem_rd_en);

    // R6
    run_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.run |-> !mem_rd_en);

    // R10
    pwr_gate_chk: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> !mem_rd_en);

endmodule

bind cmd_ring_engine cre_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pwr_down  (pwr_down),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .mem_rd_en (mem_rd_en),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_cmd    (tx_cmd),
    .cfg       (cfg),
    .rd_ptr    (rd_ptr)
);

// File: tb/cmd_ring_engine_tb.sv
module cmd_ring_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_down = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_rd_en;
    logic [31:0] mem_addr;
    logic [31:0] mem_rd_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] tx_cmd;
    logic [3:0]  tx_codec;
    logic        ring_full;

    cmd_ring_engine u_dut (
        .clk(clk), .rst(rst), .pwr_down(pwr_down),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_cmd(tx_cmd), .tx_codec(tx_codec),
        .ring_full(ring_full)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    int ngot = 0, nmad = 0, nexp = 0, ncmp = 0;
    bit done = 0, auto_rdy = 1, man_rdy = 0;
    logic [31:0] got_cmd [0:1023];
    logic [3:0]  got_cod [0:1023];
    logic [31:0] mad     [0:1023];
    logic [31:0] exp_adr [0:1023];
    logic [7:0]  swp, mask;
    logic [31:0] cur_base;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    // memory model and transmit monitor
    always @(posedge clk) begin
        cyc++;
        if (tx_valid && tx_ready) begin
            got_cmd[ngot] = tx_cmd;
            got_cod[ngot] = tx_codec;
            ngot++;
        end
        if (mem_rd_en) begin
            mad[nmad] = mem_addr;
            nmad++;
            mem_rd_data <= memf(mem_addr);
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(negedge clk) tx_ready <= auto_rdy ? ((cyc % 3) != 1) : man_rdy;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic expect_next();
        swp = (swp + 8'd1) & mask;
        exp_adr[nexp] = cur_base + {22'd0, swp, 2'b00};
        nexp++;
    endtask

    task automatic push_one();
        logic [31:0] v;
        while (ring_full) @(negedge clk);
        rd(3'd3, v);
        // R9: full flag against bench arithmetic
        chk(ring_full == (((swp + 8'd1) & mask) == v[7:0]), "R9 full", {31'd0, ring_full}, v);
        expect_next();
        wr(3'd2, {24'd0, swp});
    endtask

    task automatic drain();
        logic [31:0] v;
        for (int i = 0; i < 20000 && ngot < nexp; i++) @(negedge clk);
        chk(ngot == nexp, "R3 count", ngot, nexp);
        for (int k = ncmp; k < ngot; k++) begin
            chk(mad[k] == exp_adr[k], "R3 addr", mad[k], exp_adr[k]);
            chk(got_cmd[k] == memf(exp_adr[k]), "R3 cmd", got_cmd[k], memf(exp_adr[k]));
            chk(got_cod[k] == memf(exp_adr[k])[31:28], "R8 codec", {28'd0, got_cod[k]},
                {28'd0, memf(exp_adr[k])[31:28]});
        end
        ncmp = ngot;
        rd(3'd3, v);
        chk(v[7:0] == swp, "R3 rdptr caught up", v, {24'd0, swp});
    endtask

    task automatic run_cfg(input logic [1:0] code, input logic [31:0] b, input int n);
        logic [31:0] v;
        int n0;
        wr(3'd4, 32'd0);
        wr(3'd1, {30'd0, code});
        wr(3'd0, b);
        cur_base = b;
        mask = (code == 2'd0) ? 8'h01 : (code == 2'd1) ? 8'h0F : 8'hFF;
        wr(3'd3, 32'h8000);
        rd(3'd3, v);
        chk(v == 32'h8000, "R5 clear readback set", v, 32'h8000);
        wr(3'd2, 32'd0);
        swp = 8'd0;
        wr(3'd3, 32'd0);
        rd(3'd3, v);
        chk(v == 32'd0, "R5 clear readback zero", v, 32'd0);
        wr(3'd4, 32'd1);
        n0 = nmad;
        repeat (8) @(negedge clk);
        chk(nmad == n0, "R4 empty after clear", nmad, n0);
        // R5: pointer clear bit held blocks fetching
        wr(3'd3, 32'h8000);
        expect_next();
        if (mask >= 8'd2) expect_next();
        wr(3'd2, {24'd0, swp});
        repeat (8) @(negedge clk);
        chk(nmad == n0, "R5 hold blocks fetch", nmad, n0);
        wr(3'd3, 32'd0);
        drain();
        // R4: first fetch after clear is slot 1
        chk(mad[n0] == b + 32'd4, "R4 slot one first", mad[n0], b + 32'd4);
        for (int i = 0; i < n; i++) push_one();
        drain();
    endtask

    initial begin
        logic [31:0] v, cmd0;
        logic [7:0]  idx1;
        int n1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(!tx_valid && !mem_rd_en, "R1 idle outputs", {30'd0, tx_valid, mem_rd_en}, 32'd0);
        rd(3'd3, v); chk(v == 32'd0, "R1 rdptr", v, 32'd0);
        rd(3'd1, v); chk(v == 32'd2, "R1 size", v, 32'd2);
        rd(3'd4, v); chk(v == 32'd0, "R1 ctrl", v, 32'd0);

        // R2: depth 2, many wraps
        run_cfg(2'd0, 32'h0000_1000, 20);
        // R2: depth 16, many wraps
        run_cfg(2'd1, 32'h0000_2040, 60);

        // R2: write pointer keeps only low bits for depth 16
        wr(3'd4, 32'd0);
        wr(3'd2, 32'h0000_00FF);
        rd(3'd2, v);
        chk(v == 32'h0F, "R2 wp masked", v, 32'h0F);
        wr(3'd2, {24'd0, swp});
        wr(3'd4, 32'd1);

        // R6 / R7: run cleared with a command waiting on the link
        auto_rdy = 0; man_rdy = 0;
        repeat (4) @(negedge clk);
        push_one();
        idx1 = swp;
        while (!tx_valid) @(negedge clk);
        cmd0 = tx_cmd;
        wr(3'd4, 32'd0);
        push_one();
        push_one();
        repeat (6) @(negedge clk);
        chk(tx_valid && tx_cmd == cmd0, "R7 hold under back-pressure", tx_cmd, cmd0);
        n1 = ngot;
        man_rdy = 1;
        repeat (10) @(negedge clk);
        chk(ngot == n1 + 1, "R6 only pending delivered", ngot, n1 + 1);
        rd(3'd3, v);
        chk(v[7:0] == idx1, "R6 rdptr stops", v, {24'd0, idx1});
        wr(3'd4, 32'd1);
        auto_rdy = 1;
        drain();

        // R10: power-down
        @(negedge clk);
        pwr_down = 1'b1;
        rd(3'd2, v);
        chk(v == 32'h0000_FFFF, "R10 wp readback", v, 32'h0000_FFFF);
        n1 = nmad;
        push_one();
        repeat (10) @(negedge clk);
        chk(nmad == n1, "R10 no fetch", nmad, n1);
        pwr_down = 1'b0;
        drain();

        // R2: depth 256 crossing the wrap, and code 3 as 256
        run_cfg(2'd2, 32'h0008_0000, 300);
        run_cfg(2'd3, 32'h0001_0000, 8);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule